// File: doc/BRIEF.md
# Parallel Flash Host Bus Front End

This block is the host-facing bus stage of a parallel NOR-style memory, modelled in a single clock domain. The raw control pins (three chip enables, output enable, write enable, power-down and bus-width select), together with the address and data lines, are sampled through a two-flop synchronizer. From the sampled levels the block decides whether the part is selected. It turns every host write cycle into one clock-wide strobe that carries the captured address and data. It also answers host reads from a one-page buffer that is filled from an abstract array port.

Two state machines carry the behaviour. The write tracker has the states WR_IDLE and WR_ARMED. It moves from WR_IDLE to WR_ARMED while a selected write is in progress (enabled, write enable low, power-down released). It returns from WR_ARMED to WR_IDLE when that condition ends, and emits the strobe on that transition unless power-down caused it. The page buffer has the states PG_EMPTY, PG_FETCH and PG_READY. It moves from PG_EMPTY to PG_FETCH on any read. It moves from PG_READY to PG_FETCH on a read whose page differs from the buffered tag. It moves from PG_FETCH to PG_READY when the array acknowledges. Every state returns to PG_EMPTY on a flush, which is power-down or a committed write.

Top module: `pflash_bus_fe`

## Requirements
- R1: The part is selected when en2/en1/en0 are 000, 100, 101 or 110 (written en2,en1,en0) and power-down is released. The codes 001, 010, 011 and 111 deselect it, and a deselected part drives no data lane.
- R2: A selected write ends when wr_en_n_i rises and produces exactly one wr_stb_o pulse. That pulse carries the address and data sampled while the write was active, with wr_byte_o giving the bus width. In word mode the address bit 0 is forced to 0. In byte mode data bits 15:8 are 0.
- R3: If the part is deselected while wr_en_n_i is still low, that deselection commits the write with one strobe. The later rise of wr_en_n_i produces no second strobe.
- R4: While pwrdn_n_i is low, both data lanes are off and no write strobe is produced. A write cut short by power-down is dropped. The page buffer is emptied, so the next read fetches again.
- R5: With out_en_n_i high (or wr_en_n_i low), bus_q_en_o is 00.
- R6: In word mode (wide_i=1), bus_q_en_o is 11 and bus_q_o is word bus_addr_i[2:1] of the page. Word i sits at bits 16*i+15:16*i of arr_data_i. Address bit 0 has no effect.
- R7: In byte mode (wide_i=0), bus_q_en_o is 01 and bus_q_o[7:0] is byte bus_addr_i[2:0] of the page, little-endian within each word. Bits 15:8 of bus_q_o are 0.
- R8: A read whose page (bus_addr_i[AW-1:3]) is not buffered raises arr_req_o with arr_addr_o equal to that page. arr_req_o and arr_addr_o hold until arr_ack_i. Meanwhile rd_busy_o is high and no lane is driven. Reads within the buffered page make no new request.
- R9: A committed write empties the page buffer, so the next read of the same page fetches again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset of the clocked logic |
| en0_i | input | 1 | Chip enable pin 0 (raw) |
| en1_i | input | 1 | Chip enable pin 1 (raw) |
| en2_i | input | 1 | Chip enable pin 2 (raw) |
| out_en_n_i | input | 1 | Output enable, active low |
| wr_en_n_i | input | 1 | Write enable, active low |
| pwrdn_n_i | input | 1 | Power-down/reset pin, active low |
| wide_i | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| bus_addr_i | input | AW | Byte address from the host |
| bus_d_i | input | 16 | Write data from the host |
| bus_q_o | output | 16 | Read data toward the host |
| bus_q_en_o | output | 2 | Drive enable per lane: bit 0 = low byte, bit 1 = high byte |
| rd_busy_o | output | 1 | Read pending while the page is fetched |
| wr_stb_o | output | 1 | One-cycle write commit strobe |
| wr_addr_o | output | AW | Address of the committed write |
| wr_data_o | output | 16 | Data of the committed write |
| wr_byte_o | output | 1 | Committed write was in byte mode |
| arr_req_o | output | 1 | Page fetch request |
| arr_addr_o | output | AW-3 | Page index being fetched |
| arr_ack_i | input | 1 | Array has placed the page on arr_data_i |
| arr_data_i | input | 64 | Four 16-bit words of the requested page |

## Verification
The hardest case to reach from the ports is a write whose commit comes from deselection rather than from the write-enable edge. To get there, the stimulus holds wr_en_n_i low, moves the enables into a deselecting code, and only later releases wr_en_n_i. It then counts strobes across both edges. A second hard case is a write that power-down interrupts. The bench lowers pwrdn_n_i while the tracker is armed and checks that no strobe appears. It also checks that the buffered page is refetched afterwards, which it sees through the fetch count at the array port.

// File: rtl/pfe_pkg.sv
package pfe_pkg;

    typedef enum logic [1:0] {
        PG_EMPTY = 2'd0,
        PG_FETCH = 2'd1,
        PG_READY = 2'd2
    } pg_state_e;

    typedef enum logic {
        WR_IDLE  = 1'b0,
        WR_ARMED = 1'b1
    } wr_state_e;

    localparam int WORD_W     = 16;
    localparam int PAGE_WORDS = 4;
    localparam int PAGE_W     = WORD_W * PAGE_WORDS;

    // enabled on 000, or on any code with en2 high except 111
    function automatic logic en_decode(input logic e2, input logic e1, input logic e0);
        return e2 ? ~(e1 & e0) : ~(e1 | e0);
    endfunction

endpackage

// File: rtl/pfe_sync.sv
module pfe_sync #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            stage2 <= RST_VAL;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/pfe_wr_track.sv
module pfe_wr_track
    import pfe_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          wr_n,
    input  logic          pd_n,
    input  logic          wide,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   data,
    output logic          stb,
    output logic [AW-1:0] stb_addr,
    output logic [15:0]   stb_data,
    output logic          stb_byte
);
    wr_state_e state, nxt;
    logic      wr_live;

    assign wr_live = sel & ~wr_n & pd_n;

    always_comb begin
        nxt = state;
        unique case (state)
            WR_IDLE:  nxt = wr_live ? WR_ARMED : WR_IDLE;
            WR_ARMED: nxt = wr_live ? WR_ARMED : WR_IDLE;
            default:  nxt = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= WR_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb      <= 1'b0;
            stb_addr <= '0;
            stb_data <= '0;
            stb_byte <= 1'b0;
        end else begin
            stb <= (state == WR_ARMED) && (nxt == WR_IDLE) && pd_n;
            if (wr_live) begin
                stb_addr <= wide ? {addr[AW-1:1], 1'b0} : addr;
                stb_data <= wide ? data : {8'h00, data[7:0]};
                stb_byte <= ~wide;
            end
        end
    end
endmodule

// File: rtl/pfe_page.sv
module pfe_page
    import pfe_pkg::*;
#(
    parameter int PW = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [PW-1:0]     page_idx,
    input  logic              flush,
    input  logic              ack,
    input  logic [PAGE_W-1:0] fill,
    output logic              req,
    output logic [PW-1:0]     req_page,
    output logic              hit,
    output logic [PAGE_W-1:0] buf_q
);
    pg_state_e   state, nxt;
    logic [PW-1:0] tag;

    always_comb begin
        nxt = state;
        unique case (state)
            PG_EMPTY: if (rd_req) nxt = PG_FETCH;
            PG_FETCH: if (ack) nxt = PG_READY;
            PG_READY: if (rd_req && page_idx != tag) nxt = PG_FETCH;
            default:  nxt = PG_EMPTY;
        endcase
        if (flush) nxt = PG_EMPTY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PG_EMPTY;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_page <= '0;
            tag      <= '0;
            buf_q    <= '0;
        end else begin
            if (state != PG_FETCH && nxt == PG_FETCH) req_page <= page_idx;
            if (state == PG_FETCH && ack && !flush) begin
                buf_q <= fill;
                tag   <= req_page;
            end
        end
    end

    assign req = (state == PG_FETCH);
    assign hit = (state == PG_READY) && (tag == page_idx);
endmodule

// File: rtl/pflash_bus_fe.sv
module pflash_bus_fe
    import pfe_pkg::*;
#(
    parameter int AW = 22
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en0_i,
    input  logic                 en1_i,
    input  logic                 en2_i,
    input  logic                 out_en_n_i,
    input  logic                 wr_en_n_i,
    input  logic                 pwrdn_n_i,
    input  logic                 wide_i,
    input  logic [AW-1:0]        bus_addr_i,
    input  logic [15:0]          bus_d_i,
    output logic [15:0]          bus_q_o,
    output logic [1:0]           bus_q_en_o,
    output logic                 rd_busy_o,
    output logic                 wr_stb_o,
    output logic [AW-1:0]        wr_addr_o,
    output logic [15:0]          wr_data_o,
    output logic                 wr_byte_o,
    output logic                 arr_req_o,
    output logic [AW-4:0]        arr_addr_o,
    input  logic                 arr_ack_i,
    input  logic [PAGE_W-1:0]    arr_data_i
);
    localparam int PW = AW - 3;
    localparam int SW = 7 + AW + 16;
    localparam logic [SW-1:0] SYNC_RST = {1'b0, 6'b111111, {AW{1'b0}}, 16'h0000};

    logic [SW-1:0] raw_v, syn_v;
    logic          pd_s, wide_s, wr_n_s, oe_n_s, e2_s, e1_s, e0_s;
    logic [AW-1:0] addr_s;
    logic [15:0]   data_s;
    logic          sel, rd_live, pg_flush, pg_hit;
    logic [PAGE_W-1:0] pg_data;
    logic [2:0]    byte_ix;
    logic [1:0]    word_ix;

    assign raw_v = {pwrdn_n_i, wide_i, wr_en_n_i, out_en_n_i, en2_i, en1_i, en0_i,
                    bus_addr_i, bus_d_i};

    pfe_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_v),
        .q     (syn_v)
    );

    assign {pd_s, wide_s, wr_n_s, oe_n_s, e2_s, e1_s, e0_s, addr_s, data_s} = syn_v;

    assign sel     = en_decode(e2_s, e1_s, e0_s) & pd_s;
    assign rd_live = sel & ~oe_n_s & wr_n_s;

    pfe_wr_track #(.AW(AW)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .wr_n     (wr_n_s),
        .pd_n     (pd_s),
        .wide     (wide_s),
        .addr     (addr_s),
        .data     (data_s),
        .stb      (wr_stb_o),
        .stb_addr (wr_addr_o),
        .stb_data (wr_data_o),
        .stb_byte (wr_byte_o)
    );

    assign pg_flush = ~pd_s | wr_stb_o;

    pfe_page #(.PW(PW)) u_page (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_live),
        .page_idx (addr_s[AW-1:3]),
        .flush    (pg_flush),
        .ack      (arr_ack_i),
        .fill     (arr_data_i),
        .req      (arr_req_o),
        .req_page (arr_addr_o),
        .hit      (pg_hit),
        .buf_q    (pg_data)
    );

    assign byte_ix = addr_s[2:0];
    assign word_ix = addr_s[2:1];

    always_comb begin
        if (wide_s) bus_q_o = pg_data[16*word_ix +: 16];
        else        bus_q_o = {8'h00, pg_data[8*byte_ix +: 8]};
        if (rd_live && pg_hit) bus_q_en_o = wide_s ? 2'b11 : 2'b01;
        else                   bus_q_en_o = 2'b00;
        rd_busy_o = rd_live & ~pg_hit;
    end
endmodule

// File: rtl/pfe_checker.sv
module pfe_checker #(
    parameter int PW = 19
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pd_s,
    input logic          wide_s,
    input logic          wr_stb,
    input logic [1:0]    q_en,
    input logic          rd_busy,
    input logic          req,
    input logic          ack,
    input logic [PW-1:0] req_page,
    input logic          flush
);
    // R2
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R4
    pd_no_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(pd_s) |-> !wr_stb);

    // R4
    pd_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_s |-> q_en == 2'b00);

    // R7
    byte_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide_s && q_en != 2'b00) |-> q_en == 2'b01);

    // R8
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_busy |-> q_en == 2'b00);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && !flush) |=> req);

    // R8
    req_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack && !flush) |=> $stable(req_page));
endmodule

bind pflash_bus_fe pfe_checker #(.PW(PW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd_s     (pd_s),
    .wide_s   (wide_s),
    .wr_stb   (wr_stb_o),
    .q_en     (bus_q_en_o),
    .rd_busy  (rd_busy_o),
    .req      (arr_req_o),
    .ack      (arr_ack_i),
    .req_page (arr_addr_o),
    .flush    (pg_flush)
);

// File: tb/tb_pflash_bus_fe.sv
module tb_pflash_bus_fe;
    localparam int AW = 22;
    localparam int PW = AW - 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en0 = 1'b1, en1 = 1'b1, en2 = 1'b1;
    logic oe_n = 1'b1, we_n = 1'b1, pd_n = 1'b1, wide = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [15:0]   din = '0;
    logic [15:0]   q;
    logic [1:0]    q_en;
    logic          busy, stb, sbyte, req;
    logic [AW-1:0] saddr;
    logic [15:0]   sdata;
    logic [PW-1:0] req_page;
    logic          ack;
    logic [63:0]   fill;

    int n_cmp = 0, n_bad = 0;
    int stb_cnt = 0, fetch_cnt = 0, busy_cnt = 0;
    logic [AW-1:0] last_addr;
    logic [15:0]   last_data;
    logic          last_byte;
    logic [PW-1:0] last_page;
    bit            done = 0;

    always #5 clk = ~clk;

    pflash_bus_fe #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .en0_i(en0), .en1_i(en1), .en2_i(en2),
        .out_en_n_i(oe_n), .wr_en_n_i(we_n), .pwrdn_n_i(pd_n), .wide_i(wide),
        .bus_addr_i(addr), .bus_d_i(din), .bus_q_o(q), .bus_q_en_o(q_en),
        .rd_busy_o(busy), .wr_stb_o(stb), .wr_addr_o(saddr), .wr_data_o(sdata),
        .wr_byte_o(sbyte), .arr_req_o(req), .arr_addr_o(req_page),
        .arr_ack_i(ack), .arr_data_i(fill)
    );

    function automatic logic [15:0] wexp(int p, int i);
        return 16'((p * 16'h0123) ^ (i * 16'h1111) ^ 16'h5A00);
    endfunction

    function automatic logic [7:0] bexp(int p, int k);
        logic [15:0] w;
        w = wexp(p, k >> 1);
        return (k & 1) ? w[15:8] : w[7:0];
    endfunction

    always_comb
        for (int i = 0; i < 4; i++) fill[16*i +: 16] = wexp(int'(req_page), i);

    always @(posedge clk) begin
        if (!rst_n) ack <= 1'b0;
        else begin
            ack <= req && !ack;
            if (ack) begin
                fetch_cnt <= fetch_cnt + 1;
                last_page <= req_page;
            end
            if (stb) begin
                stb_cnt   <= stb_cnt + 1;
                last_addr <= saddr;
                last_data <= sdata;
                last_byte <= sbyte;
            end
            if (busy) busy_cnt <= busy_cnt + 1;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [AW-1:0] wa(int p, int w, int lsb);
        return AW'((p << 3) | (w << 1) | lsb);
    endfunction

    // {en2, en1, en0, selected}
    localparam logic [3:0] EN_VEC [8] = '{
        4'b0001, 4'b0010, 4'b0100, 4'b0110,
        4'b1001, 4'b1011, 4'b1101, 4'b1110
    };

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int f0, s0, b0;
        tick(3);
        rst_n = 1'b1;
        tick(6);
        // R4 R5 reset state: nothing driven, no strobe
        chk("R5 reset lanes", 32'(q_en), 32'(2'b00));
        chk("R2 reset strobes", stb_cnt, 0);
        chk("R8 reset busy", 32'(busy), 32'(0));

        // R1 enable truth table, walked with a read of page 5 word 2
        oe_n = 1'b0; wide = 1'b1; addr = wa(5, 2, 0);
        foreach (EN_VEC[i]) begin
            {en2, en1, en0} = EN_VEC[i][3:1];
            tick(10);
            chk($sformatf("R1 code %b lanes", EN_VEC[i][3:1]), 32'(q_en),
                EN_VEC[i][0] ? 32'(2'b11) : 32'(2'b00));
            if (EN_VEC[i][0]) chk("R1 data", 32'(q), 32'(wexp(5, 2)));
        end

        // R6 word reads inside the page, A0 set; R8 no refetch
        {en2, en1, en0} = 3'b000;
        tick(10);
        f0 = fetch_cnt;
        for (int w = 0; w < 4; w++) begin
            addr = wa(5, w, 1);
            tick(6);
            chk("R6 word data", 32'(q), 32'(wexp(5, w)));
            chk("R6 lanes", 32'(q_en), 32'(2'b11));
        end
        chk("R8 hit no fetch", fetch_cnt - f0, 0);

        // R7 byte mode
        wide = 1'b0;
        for (int k = 0; k < 8; k++) begin
            addr = AW'((5 << 3) | k);
            tick(6);
            chk("R7 byte data", 32'(q), 32'({8'h00, bexp(5, k)}));
            chk("R7 lanes", 32'(q_en), 32'(2'b01));
        end
        wide = 1'b1;

        // R8 miss: new page fetched, busy seen
        f0 = fetch_cnt; b0 = busy_cnt;
        addr = wa(77, 3, 0);
        tick(12);
        chk("R8 one fetch", fetch_cnt - f0, 1);
        chk("R8 page index", 32'(last_page), 32'(77));
        chk("R8 busy seen", 32'(busy_cnt > b0), 32'(1));
        chk("R8 data", 32'(q), 32'(wexp(77, 3)));

        // R5 output enable high
        oe_n = 1'b1;
        tick(6);
        chk("R5 oe high lanes", 32'(q_en), 32'(2'b00));

        // R2 word write
        s0 = stb_cnt;
        addr = 22'h012345; din = 16'hBEEF; we_n = 1'b0;
        tick(6);
        we_n = 1'b1;
        tick(6);
        chk("R2 one strobe", stb_cnt - s0, 1);
        chk("R2 addr", 32'(last_addr), 32'(22'h012344));
        chk("R2 data", 32'(last_data), 32'(16'hBEEF));
        chk("R2 width", 32'(last_byte), 32'(0));

        // R2 byte write
        s0 = stb_cnt;
        wide = 1'b0; addr = 22'h000101; din = 16'h77C3; we_n = 1'b0;
        tick(6);
        we_n = 1'b1;
        tick(6);
        chk("R2 byte strobe", stb_cnt - s0, 1);
        chk("R2 byte addr", 32'(last_addr), 32'(22'h000101));
        chk("R2 byte data", 32'(last_data), 32'(16'h00C3));
        chk("R2 byte width", 32'(last_byte), 32'(1));
        wide = 1'b1;

        // R3 deselect commits first
        s0 = stb_cnt;
        addr = 22'h0000A0; din = 16'h1357; we_n = 1'b0;
        tick(6);
        en0 = 1'b1;
        tick(6);
        chk("R3 deselect strobe", stb_cnt - s0, 1);
        chk("R3 data", 32'(last_data), 32'(16'h1357));
        we_n = 1'b1;
        tick(6);
        en0 = 1'b0;
        tick(6);
        chk("R3 no second strobe", stb_cnt - s0, 1);

        // R4 power-down drops a write and gates reads
        oe_n = 1'b0; addr = wa(9, 1, 0);
        tick(10);
        oe_n = 1'b1;
        tick(4);
        s0 = stb_cnt;
        we_n = 1'b0; din = 16'h4444;
        tick(6);
        pd_n = 1'b0;
        tick(6);
        we_n = 1'b1;
        tick(6);
        chk("R4 dropped write", stb_cnt - s0, 0);
        oe_n = 1'b0;
        tick(6);
        chk("R4 lanes off", 32'(q_en), 32'(2'b00));
        f0 = fetch_cnt;
        pd_n = 1'b1;
        tick(12);
        chk("R4 refetch", fetch_cnt - f0, 1);
        chk("R4 data", 32'(q), 32'(wexp(9, 1)));

        // R9 write flushes the buffered page
        oe_n = 1'b1;
        tick(4);
        we_n = 1'b0; din = 16'h0F0F;
        tick(6);
        we_n = 1'b1;
        tick(6);
        f0 = fetch_cnt;
        oe_n = 1'b0;
        tick(12);
        chk("R9 refetch after write", fetch_cnt - f0, 1);
        chk("R9 data", 32'(q), 32'(wexp(9, 1)));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule